// File: doc/BRIEF.md
# Nested Bias Sweep Sequencer

This block produces the two digital setpoint streams for a two-terminal-pair current–voltage sweep. One stream is the ramp axis, the drain or collector setpoint. The other is the step axis, the gate or base setpoint. For every step value, the ramp axis runs through a linear set of points from a first code to a last code. Only then does the step axis move to its next value. Every applied point raises a one-cycle sample strobe, and the strobe carries a nanosecond timestamp.

There are two modes. In DC mode each point is held for a programmed number of clock cycles. In pulsed mode the ramp setpoint is applied for a pulse width that is clamped to the legal range. After the pulse, the ramp output falls back to the rest code for 999 times the pulse width, which keeps the duty cycle at or below one in a thousand.

A compliance fault drives both outputs to the rest code within one clock cycle and sets a sticky flag. The sweep can be started again only after software clears that flag.

Top module: `bias_sweep_seq`

## Requirements
- R1: While reset is asserted, both codes are 0 and `sample_stb`, `done`, `busy` and `fault_flag` are low. In idle, both codes follow `rest_code`.
- R2: A ramp axis programmed with first code A, last code B and N points applies these codes in order: A + trunc((B − A)·k/(N − 1)) for k = 0..N−1, with truncation toward zero. A count of 0 or 1 gives the single point A. The step axis uses the same rule. The whole ramp axis runs at one step value before the step index advances.
- R3: A set descend bit on an axis reverses its point order, so index k applies the code of index N−1−k.
- R4: In DC mode each point is held for `dwell_cycles` cycles, and a value of 0 counts as 1. `sample_stb` is high only in the first cycle of each point, and only while `busy` is high.
- R5: In pulsed mode the ramp code is held for P cycles. The ramp output then holds `rest_code` for 999·P cycles, and only after that does the next point start. The step code stays unchanged during the off time.
- R6: P equals `pulse_cycles` clamped to the range [10, 1 000 000] cycles. These bounds are 100 ns and 10 ms at the default 10 ns clock.
- R7: `sample_ts` equals 10 times the number of rising clock edges since reset was released, counted up to and including the edge that raised `sample_stb`.
- R8: `done` is a one-cycle pulse on the edge after the last point period ends. On that same edge both codes return to `rest_code` and `busy` falls.
- R9: If `fault_in` is high at a clock edge, then after that edge both codes equal `rest_code`, `busy` is low and `fault_flag` is high.
- R10: While `fault_flag` is set, `start` is ignored. A `fault_clr` pulse with `fault_in` low clears the flag, and after that a new `start` works.
- R11: A `start` pulse while `busy` is high has no effect on the running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch the configuration and begin a sweep |
| pulsed_mode | input | 1 | 1 selects pulsed mode, 0 selects DC mode |
| ramp_first | input | 16 | Ramp axis first code |
| ramp_last | input | 16 | Ramp axis last code |
| ramp_count | input | 12 | Ramp axis point count |
| ramp_desc | input | 1 | Reverse the ramp axis order |
| step_first | input | 16 | Step axis first code |
| step_last | input | 16 | Step axis last code |
| step_count | input | 12 | Step axis point count |
| step_desc | input | 1 | Reverse the step axis order |
| dwell_cycles | input | DWELL_W | Cycles per point in DC mode |
| pulse_cycles | input | PW_W | Requested pulse width in cycles |
| rest_code | input | 16 | Safe code for idle, off time and fault |
| fault_in | input | 1 | Compliance fault |
| fault_clr | input | 1 | Clear the sticky fault flag |
| ramp_code | output | 16 | Ramp (drain) setpoint |
| step_code | output | 16 | Step (gate) setpoint |
| sample_stb | output | 1 | One pulse per applied point |
| sample_ts | output | TS_W | Timestamp of the point, in ns |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | The sweep completed normally |
| fault_flag | output | 1 | Sticky fault indication |

## Verification
The bench builds the block with its default parameters: a 10 ns clock, a 999 off ratio, and pulse bounds of 10 to 1 000 000 cycles. With these values one clamped minimum pulse point lasts 10 000 cycles, so the bench can run several complete pulsed points and exercise the lower clamp inside its cycle budget. The upper clamp cannot be reached within that budget. The 12-bit point counts allow any short sweep, so randomly drawn sweeps of up to five by three points cover ascending and descending spans, spans where the first code is above the last, and single-point axes.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  localparam int CODE_W = 16;
  localparam int IDX_W  = 12;
  localparam int PROD_W = CODE_W + IDX_W + 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [1:0] {S_IDLE, S_ON, S_OFF} phase_e;

  typedef struct packed {
    code_t lo;
    code_t hi;
    idx_t  n;
    logic  desc;
  } axis_cfg_t;

  // Linear interpolation across npts points, endpoints inclusive,
  // quotient truncated toward zero.
  function automatic code_t ramp_point(code_t a, code_t b, idx_t npts,
                                       idx_t k, logic desc);
    logic signed [CODE_W:0]   span;
    logic signed [IDX_W:0]    pos;
    logic signed [IDX_W:0]    den;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] quo;
    if (npts < idx_t'(2)) return a;
    pos  = desc ? $signed({1'b0, npts - idx_t'(1) - k}) : $signed({1'b0, k});
    den  = $signed({1'b0, npts - idx_t'(1)});
    span = $signed({1'b0, b}) - $signed({1'b0, a});
    prod = PROD_W'(span) * PROD_W'(pos);
    quo  = prod / PROD_W'(den);
    return code_t'(PROD_W'($signed({1'b0, a})) + quo);
  endfunction

endpackage

// File: rtl/sweep_axis.sv
module sweep_axis
  import sweep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  idx_t npts,
  output idx_t idx_nxt,
  output logic last
);

  idx_t idx_q;

  assign last = (npts <= idx_t'(1)) || (idx_q == npts - idx_t'(1));

  always_comb begin
    if (clr)      idx_nxt = '0;
    else if (adv) idx_nxt = last ? '0 : idx_q + idx_t'(1);
    else          idx_nxt = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nxt;
  end

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int PW_W      = 20,
  parameter int DWELL_W   = 16,
  parameter int PW_MIN    = 10,
  parameter int PW_MAX    = 1000000,
  parameter int OFF_RATIO = 999
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               pulsed,
  input  logic               off_phase,
  input  logic [DWELL_W-1:0] dwell,
  input  logic [PW_W-1:0]    pulse_w,
  output logic               expire
);

  localparam int LEN_W = PW_W + $clog2(OFF_RATIO + 1);

  function automatic logic [PW_W-1:0] clamp_pw(logic [PW_W-1:0] w);
    if (w < PW_W'(PW_MIN)) return PW_W'(PW_MIN);
    if (w > PW_W'(PW_MAX)) return PW_W'(PW_MAX);
    return w;
  endfunction

  logic [PW_W-1:0]  pw_eff;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt_q;

  always_comb begin
    pw_eff = clamp_pw(pulse_w);
    if (!pulsed)        len = (dwell == '0) ? LEN_W'(1) : LEN_W'(dwell);
    else if (off_phase) len = LEN_W'(pw_eff) * LEN_W'(OFF_RATIO);
    else                len = LEN_W'(pw_eff);
  end

  assign expire = (cnt_q == len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + LEN_W'(1);
  end

endmodule

// File: rtl/bias_sweep_seq.sv
module bias_sweep_seq
  import sweep_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int DWELL_W   = 16,
  parameter int PW_W      = 20,
  parameter int TS_W      = 48,
  parameter int PW_MIN_NS = 100,
  parameter int PW_MAX_NS = 10000000,
  parameter int OFF_RATIO = 999
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               pulsed_mode,
  input  logic [15:0]        ramp_first,
  input  logic [15:0]        ramp_last,
  input  logic [IDX_W-1:0]   ramp_count,
  input  logic               ramp_desc,
  input  logic [15:0]        step_first,
  input  logic [15:0]        step_last,
  input  logic [IDX_W-1:0]   step_count,
  input  logic               step_desc,
  input  logic [DWELL_W-1:0] dwell_cycles,
  input  logic [PW_W-1:0]    pulse_cycles,
  input  logic [15:0]        rest_code,
  input  logic               fault_in,
  input  logic               fault_clr,
  output logic [15:0]        ramp_code,
  output logic [15:0]        step_code,
  output logic               sample_stb,
  output logic [TS_W-1:0]    sample_ts,
  output logic               busy,
  output logic               done,
  output logic               fault_flag
);

  localparam int NAX        = 2;
  localparam int PW_MIN_CYC = (PW_MIN_NS + CLK_NS - 1) / CLK_NS;
  localparam int PW_MAX_CYC = PW_MAX_NS / CLK_NS;

  phase_e             phase_q;
  axis_cfg_t          cfg_q   [NAX];
  axis_cfg_t          cfg_in  [NAX];
  axis_cfg_t          cfg_use [NAX];
  idx_t               ax_nxt  [NAX];
  logic               ax_last [NAX];
  logic               ax_adv  [NAX];
  code_t              pt_code [NAX];
  logic               pulsed_q;
  logic [DWELL_W-1:0] dwell_q;
  logic [PW_W-1:0]    pw_q;
  logic [TS_W-1:0]    tick_q;

  // Named sequencing events
  logic go, expire, pt_end, final_pt, nxt_pt, finish, on_end;

  assign busy     = (phase_q != S_IDLE);
  assign go       = start && !busy && !fault_flag && !fault_in;
  assign on_end   = (phase_q == S_ON) && pulsed_q && expire;
  assign pt_end   = expire && (((phase_q == S_ON) && !pulsed_q) || (phase_q == S_OFF));
  assign final_pt = ax_last[0] && ax_last[1];
  assign nxt_pt   = pt_end && !final_pt;
  assign finish   = pt_end && final_pt;

  always_comb begin
    cfg_in[0] = '{lo: ramp_first, hi: ramp_last, n: ramp_count, desc: ramp_desc};
    cfg_in[1] = '{lo: step_first, hi: step_last, n: step_count, desc: step_desc};
  end

  // Ramp axis advances every point; step axis when ramp axis wraps.
  assign ax_adv[0] = nxt_pt;
  assign ax_adv[1] = nxt_pt && ax_last[0];

  genvar g;
  generate
    for (g = 0; g < NAX; g++) begin : g_axis
      assign cfg_use[g] = go ? cfg_in[g] : cfg_q[g];
      assign pt_code[g] = ramp_point(cfg_use[g].lo, cfg_use[g].hi, cfg_use[g].n,
                                     ax_nxt[g], cfg_use[g].desc);
      sweep_axis u_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go),
        .adv     (ax_adv[g]),
        .npts    (cfg_q[g].n),
        .idx_nxt (ax_nxt[g]),
        .last    (ax_last[g])
      );
    end
  endgenerate

  phase_timer #(
    .PW_W      (PW_W),
    .DWELL_W   (DWELL_W),
    .PW_MIN    (PW_MIN_CYC),
    .PW_MAX    (PW_MAX_CYC),
    .OFF_RATIO (OFF_RATIO)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (go || expire),
    .pulsed    (pulsed_q),
    .off_phase (phase_q == S_OFF),
    .dwell     (dwell_q),
    .pulse_w   (pw_q),
    .expire    (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= S_IDLE;
      for (int i = 0; i < NAX; i++) cfg_q[i] <= '0;
      pulsed_q   <= 1'b0;
      dwell_q    <= '0;
      pw_q       <= '0;
      tick_q     <= '0;
      ramp_code  <= '0;
      step_code  <= '0;
      sample_stb <= 1'b0;
      sample_ts  <= '0;
      done       <= 1'b0;
      fault_flag <= 1'b0;
    end else begin
      tick_q     <= tick_q + TS_W'(CLK_NS);
      sample_stb <= 1'b0;
      done       <= 1'b0;
      if (fault_in) begin
        phase_q    <= S_IDLE;
        ramp_code  <= rest_code;
        step_code  <= rest_code;
        fault_flag <= 1'b1;
      end else begin
        if (fault_clr) fault_flag <= 1'b0;
        if (go || nxt_pt) begin
          if (go) begin
            for (int i = 0; i < NAX; i++) cfg_q[i] <= cfg_in[i];
            pulsed_q <= pulsed_mode;
            dwell_q  <= dwell_cycles;
            pw_q     <= pulse_cycles;
          end
          phase_q    <= S_ON;
          ramp_code  <= pt_code[0];
          step_code  <= pt_code[1];
          sample_stb <= 1'b1;
          sample_ts  <= tick_q + TS_W'(CLK_NS);
        end else if (finish) begin
          phase_q   <= S_IDLE;
          ramp_code <= rest_code;
          step_code <= rest_code;
          done      <= 1'b1;
        end else if (on_end) begin
          phase_q   <= S_OFF;
          ramp_code <= rest_code;
        end else if (phase_q == S_IDLE) begin
          ramp_code <= rest_code;
          step_code <= rest_code;
        end
      end
    end
  end

  // R9: a fault forces the safe code and idles the sequencer one edge later
  p_fault_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> (ramp_code == $past(rest_code)) && (step_code == $past(rest_code))
                 && !busy && fault_flag);

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: strobes only mark points of a running sweep
  p_stb_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> busy);

  // R10: a set fault flag keeps the sequencer idle on the next cycle
  p_flag_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |=> !busy);

  // R5: during the off time the ramp output does not move
  p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == S_OFF) && $past(phase_q == S_OFF) && $stable(rest_code)
    |-> $stable(ramp_code));

  // R5: the step setpoint is held across the pulse-to-off transition
  p_step_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == S_OFF) |-> $stable(step_code));

endmodule

// File: tb/bias_sweep_seq_test.sv
module bias_sweep_seq_test;
  import sweep_pkg::*;

  localparam int RC = 16'h7FF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, pulsed_mode = 1'b0;
  logic [15:0] ramp_first = '0, ramp_last = '0, step_first = '0, step_last = '0;
  logic [11:0] ramp_count = '0, step_count = '0;
  logic        ramp_desc = 1'b0, step_desc = 1'b0;
  logic [15:0] dwell_cycles = '0;
  logic [19:0] pulse_cycles = '0;
  logic [15:0] rest_code = 16'(RC);
  logic        fault_in = 1'b0, fault_clr = 1'b0;
  logic [15:0] ramp_code, step_code;
  logic        sample_stb, busy, done, fault_flag;
  logic [47:0] sample_ts;

  int     checks = 0, fails = 0;
  bit     finished = 0;
  longint edges;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  bias_sweep_seq uut (.*);

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(int a, int b, int n, int k, bit desc);
    int i;
    if (n < 2) return a;
    i = desc ? (n - 1 - k) : k;
    return a + ((b - a) * i) / (n - 1);
  endfunction

  function automatic int exp_pw(int pw);
    if (pw < 10) return 10;
    if (pw > 1000000) return 1000000;
    return pw;
  endfunction

  task automatic run_sweep(int ra, int rb, int rn, bit rd, int sa, int sb, int sn, bit sd,
                           bit pm, int dw, int pw, bit poke, string tag);
    int on_len, off_len, nr, ns;
    ramp_first = 16'(ra); ramp_last = 16'(rb); ramp_count = 12'(rn); ramp_desc = rd;
    step_first = 16'(sa); step_last = 16'(sb); step_count = 12'(sn); step_desc = sd;
    pulsed_mode = pm; dwell_cycles = 16'(dw); pulse_cycles = 20'(pw);
    on_len  = pm ? exp_pw(pw) : ((dw == 0) ? 1 : dw);
    off_len = pm ? 999 * on_len : 0;
    nr = (rn < 1) ? 1 : rn;
    ns = (sn < 1) ? 1 : sn;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int o = 0; o < ns; o++) begin
      for (int i = 0; i < nr; i++) begin
        int er, es, bad;
        er = exp_code(ra, rb, rn, i, rd);
        es = exp_code(sa, sb, sn, o, sd);
        bad = 0;
        check(sample_stb === 1'b1 && busy === 1'b1, {tag, " R4 strobe at point start"}, sample_stb, 1);
        check(ramp_code == 16'(er), {tag, " R2 ramp code"}, ramp_code, er);
        check(step_code == 16'(es), {tag, " R2 step code"}, step_code, es);
        check(sample_ts == 48'(edges * 10), {tag, " R7 timestamp"}, sample_ts, edges * 10);
        for (int j = 1; j < on_len; j++) begin
          if (poke && o == 0 && i == 0) start = (j == 1);
          @(negedge clk);
          if (sample_stb !== 1'b0 || ramp_code != 16'(er) || step_code != 16'(es)) bad++;
        end
        start = 1'b0;
        for (int j = 0; j < off_len; j++) begin
          @(negedge clk);
          if (sample_stb !== 1'b0 || ramp_code != rest_code || step_code != 16'(es)) bad++;
        end
        check(bad == 0, {tag, " R4 R5 R11 hold and off time"}, bad, 0);
        @(negedge clk);
      end
    end
    check(done === 1'b1 && busy === 1'b0 && ramp_code == rest_code && step_code == rest_code,
          {tag, " R8 done and rest"}, done, 1);
    @(negedge clk);
    check(done === 1'b0, {tag, " R8 done single cycle"}, done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ramp_code == 0 && step_code == 0 && !sample_stb && !done && !busy && !fault_flag,
          "R1 reset state", ramp_code, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ramp_code == rest_code && step_code == rest_code, "R1 idle rest code", ramp_code, RC);

    // R2 R4 R7 R8: directed ascending DC sweep
    run_sweep(100, 1100, 5, 0, 2000, 3000, 3, 0, 0, 3, 0, 0, "dc-up");
    // R3: both axes descending, dwell 0 counts as 1 (R4)
    run_sweep(500, 40000, 4, 1, 9000, 100, 3, 1, 0, 0, 0, 0, "R3 desc");
    // R2: zero counts give a single point
    run_sweep(1234, 60000, 0, 0, 777, 5, 0, 0, 0, 2, 0, 0, "R2 single");
    // R11: start during a running sweep is ignored
    run_sweep(0, 65535, 3, 0, 10, 20, 1, 0, 0, 10, 0, 1, "R11 restart");

    // Random DC sweeps
    for (int t = 0; t < 6; t++) begin
      run_sweep(int'($urandom % 65536), int'($urandom % 65536), int'(1 + $urandom % 5),
                bit'($urandom % 2), int'($urandom % 65536), int'($urandom % 65536),
                int'(1 + $urandom % 3), bit'($urandom % 2), 0, int'($urandom % 4), 0, 0,
                "rand");
    end

    // R5 R6: pulsed, width below the minimum is clamped to 10 cycles
    run_sweep(1000, 2000, 2, 0, 300, 400, 2, 0, 1, 0, 3, 0, "R5 R6 pulsed-min");
    // R5: pulsed, legal width used as programmed
    run_sweep(4242, 9, 1, 0, 555, 1, 1, 0, 1, 0, 12, 0, "R5 pulsed-12");

    // R9: fault mid-sweep
    ramp_first = 16'd50; ramp_last = 16'd60; ramp_count = 12'd3; ramp_desc = 1'b0;
    step_count = 12'd1; pulsed_mode = 1'b0; dwell_cycles = 16'd20;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    check(busy === 1'b1, "R9 sweep running before fault", busy, 1);
    fault_in = 1'b1;
    @(negedge clk);
    check(ramp_code == rest_code && step_code == rest_code, "R9 codes at rest", ramp_code, RC);
    check(busy === 1'b0 && fault_flag === 1'b1, "R9 idle and flagged", fault_flag, 1);
    fault_in = 1'b0;
    // R10: start ignored while flagged
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    begin
      int seen = 0;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (busy !== 1'b0 || sample_stb !== 1'b0) seen++;
      end
      check(seen == 0 && fault_flag === 1'b1, "R10 start blocked by flag", seen, 0);
    end
    fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
    check(fault_flag === 1'b0, "R10 flag cleared", fault_flag, 0);
    run_sweep(7, 70, 2, 0, 8, 80, 2, 0, 0, 2, 0, 0, "R10 after clear");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule